// File: doc/BRIEF.md
# Redundant-Frame SPI Register Slave

This block lets a host controller read and write a bank of 32-bit registers over a four-wire SPI link using fixed 64-bit frames. Each frame opens with a 24-bit command: an address and a read/write bit, then the bitwise complement of both. An 8-bit status byte follows that describes the frame before it, and the frame ends with a 32-bit data word sent MSB first. The slave rejects frames whose complement copy disagrees, frames that are not exactly 64 clocks long, and addresses outside the implemented range. It reports every such fault one frame later in the status byte.

The SPI pins are synchronised into the system clock domain. The system clock must run at least four times faster than the SPI clock. Input bits are taken on the SPI rising edge and output bits change on the falling edge. A write reaches the register bus only when chip select rises after a clean frame. A read is issued on the register bus as soon as the command has been checked. The register bus is a single-cycle port with no back-pressure: `reg_rdata` must be valid in the same cycle that `reg_rd` is high, and `reg_wr` is a one-cycle strobe that the register file must accept. Two words are handled inside the block. One is a lock word that, while armed, blocks every other write. The other is a reset trigger that raises a one-cycle reset request toward the rest of the device.

Top module: `rsf_spi_slave`

## Requirements
- R1: A read frame whose command is consistent and whose address is at most 0x3FF issues exactly one `reg_rd` with that address. The word returned on `reg_rdata` is shifted out on `spi_miso` in frame bits 32 to 63, MSB first. Bits 0 to 23 are shifted out as zero.
- R2: Frame bits 24 to 31 carry the status byte, MSB first. It describes the previous frame, with this layout: bit 6 FIFO overrun, bit 5 FIFO underrun, bit 4 data parity, bit 3 command mismatch, bit 2 always 0, bit 1 length error, bit 0 out-of-bounds. Bit 7 is set so that the byte has even parity.
- R3: If the complemented address or direction in bits 12 to 23 does not match bits 0 to 11, no register access takes place. The read data is all zeros, and the next status has bit 3 set. This check applies only to frames of at least 24 clocks.
- R4: A frame with any clock count other than 64 sets status bit 1 in the next frame. A write in such a frame is never committed. Clocks after bit 63 of a read shift out zeros.
- R5: A clean 64-clock write frame to a legal address produces one `reg_wr` after chip select rises, carrying the frame's address and data.
- R6: An address above 0x3FF sets status bit 0. No bus access takes place, and a read of such an address returns zero.
- R7: Status bit 4 is the XOR of the 32 data bits of the previous frame. For a read this is the word sent; for a write it is the word received. The address is never included.
- R8: Writing 0x8000_0000 to address 0x325 arms the lock. While the lock is armed, writes to any other address are dropped and set status bit 0, while reads still work. Writing zero to 0x325 disarms the lock. Reading 0x325 returns the lock word.
- R9: Writing 0x8100_0000 to address 0x322 raises `rst_req` for exactly one cycle. Writing any other value there does nothing.
- R10: A pulse on `fifo_ovf` or `fifo_unf` sets status bit 6 or bit 5 in the next frame to start. The flag is cleared for the frame after that.
- R11: While `spi_sel_n` is high, `spi_miso_en` is low and clock and data activity has no effect: no bus access occurs and the status of the next frame is unchanged.
- R12: After reset, the first frame's status byte is 0x00, and `rst_req` and `reg_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SPI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| spi_miso_en | output | 1 | Output enable for the `spi_miso` pad driver; low gives high impedance |
| fifo_ovf | input | 1 | FIFO overrun event strobe |
| fifo_unf | input | 1 | FIFO underrun event strobe |
| reg_addr | output | 11 | Register bus address |
| reg_rd | output | 1 | Register bus read strobe |
| reg_wr | output | 1 | Register bus write strobe |
| reg_wdata | output | 32 | Register bus write data |
| reg_rdata | input | 32 | Register bus read data, valid while `reg_rd` is high |
| rst_req | output | 1 | One-cycle device reset request |

## Verification
The hardest situations to reach are frames that are one clock short or one clock long. Every status flag is only visible one frame later. The bench therefore drives SPI frames bit by bit with a programmable clock count and a switch that corrupts the complemented address. It predicts each next status byte from a running model of the previous frame's faults. The lock case needs a specific sequence: arm the lock, attempt a write that must be dropped, read the target back through the normal read path, then disarm the lock and repeat the write.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef struct packed {
    logic ovf;
    logic unf;
    logic dpar;
    logic mis;
    logic len_err;
    logic oob;
  } rsf_flags_t;

  function automatic logic [7:0] rsf_status(input rsf_flags_t f);
    logic [7:0] b;
    b = {1'b0, f.ovf, f.unf, f.dpar, f.mis, 1'b0, f.len_err, f.oob};
    b[7] = ^b[6:0];
    return b;
  endfunction
endpackage

// File: rtl/rsf_sync.sv
module rsf_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rsf_frame.sv
module rsf_frame #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int STAT_W = 8,
  localparam int CMD_BITS = 2 * ADDR_W + 2,
  localparam int FRAME_BITS = CMD_BITS + STAT_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n_s,
  input  logic                sck_s,
  input  logic                mosi_s,
  input  logic [STAT_W-1:0]   status_in,
  input  logic [DATA_W-1:0]   tx_word,
  output logic                f_start,
  output logic                f_stop,
  output logic                cmd_ready,
  output logic [CMD_BITS-1:0] cmd,
  output logic [DATA_W-1:0]   rx_word,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic                miso,
  output logic                miso_en
);
  localparam int SI_W = $clog2(STAT_W);
  localparam int DI_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] C_CMD   = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] C_DAT   = CNT_W'(CMD_BITS + STAT_W);
  localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] C_SAT   = CNT_W'(FRAME_BITS + 1);

  logic sck_q, sel_q, rise, fall;
  logic [STAT_W-1:0] stat_q;
  logic [CNT_W-1:0] s_off, d_off;
  logic tx_bit;

  assign rise    = sck_s & ~sck_q & ~sel_n_s;
  assign fall    = ~sck_s & sck_q & ~sel_n_s;
  assign f_start = sel_q & ~sel_n_s;
  assign f_stop  = ~sel_q & sel_n_s;
  assign miso_en = ~sel_n_s;

  assign s_off = C_DAT - 1'b1 - bit_cnt;
  assign d_off = C_FRAME - 1'b1 - bit_cnt;

  always_comb begin
    tx_bit = 1'b0;
    if (bit_cnt >= C_CMD && bit_cnt < C_DAT)
      tx_bit = stat_q[s_off[SI_W-1:0]];
    else if (bit_cnt >= C_DAT && bit_cnt < C_FRAME)
      tx_bit = tx_word[d_off[DI_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      sel_q     <= 1'b1;
      bit_cnt   <= '0;
      cmd       <= '0;
      rx_word   <= '0;
      stat_q    <= '0;
      miso      <= 1'b0;
      cmd_ready <= 1'b0;
    end else begin
      sck_q     <= sck_s;
      sel_q     <= sel_n_s;
      cmd_ready <= rise && (bit_cnt == C_CMD - 1'b1);
      if (f_start) begin
        bit_cnt <= '0;
        cmd     <= '0;
        rx_word <= '0;
        stat_q  <= status_in;
        miso    <= 1'b0;
      end else if (rise) begin
        if (bit_cnt != C_SAT) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < C_CMD)
          cmd <= {cmd[CMD_BITS-2:0], mosi_s};
        else if (bit_cnt >= C_DAT && bit_cnt < C_FRAME)
          rx_word <= {rx_word[DATA_W-2:0], mosi_s};
      end else if (fall) begin
        miso <= tx_bit;
      end else if (sel_n_s) begin
        miso <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsf_ctrl.sv
module rsf_ctrl
  import rsf_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int STAT_W = 8,
  parameter logic [ADDR_W-1:0] REG_TOP   = 11'h3FF,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 11'h325,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 11'h322,
  parameter logic [DATA_W-1:0] RST_KEY   = 32'h8100_0000,
  localparam int CMD_BITS = 2 * ADDR_W + 2,
  localparam int FRAME_BITS = CMD_BITS + STAT_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                f_start,
  input  logic                f_stop,
  input  logic                cmd_ready,
  input  logic [CMD_BITS-1:0] cmd,
  input  logic [DATA_W-1:0]   rx_word,
  input  logic [CNT_W-1:0]    bit_cnt,
  input  logic                fifo_ovf,
  input  logic                fifo_unf,
  input  logic [DATA_W-1:0]   reg_rdata,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic                reg_rd,
  output logic                reg_wr,
  output logic [DATA_W-1:0]   reg_wdata,
  output logic                rst_req,
  output logic                locked,
  output logic [DATA_W-1:0]   tx_word,
  output logic [STAT_W-1:0]   status
);
  localparam logic [CNT_W-1:0] C_CMD   = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME_BITS);

  logic [ADDR_W-1:0] c_addr, c_naddr;
  logic c_dir, c_ndir, c_match, c_oob;
  logic dir_q, match_q, oob_q, clean;
  logic acc_ovf, acc_unf;
  logic [DATA_W-1:0] lock_q;
  rsf_flags_t prev;

  assign c_addr  = cmd[CMD_BITS-1 -: ADDR_W];
  assign c_dir   = cmd[ADDR_W+1];
  assign c_naddr = cmd[ADDR_W:1];
  assign c_ndir  = cmd[0];
  assign c_match = (c_naddr == ~c_addr) && (c_ndir == ~c_dir);
  assign locked  = lock_q[DATA_W-1];
  assign c_oob   = (c_addr > REG_TOP) || (!c_dir && locked && c_addr != LOCK_ADDR);
  assign clean   = (bit_cnt == C_FRAME) && match_q && !dir_q && !oob_q;

  always_comb begin
    rsf_flags_t f;
    f = prev;
    f.ovf = acc_ovf;
    f.unf = acc_unf;
    status = rsf_status(f);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr  <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      rst_req   <= 1'b0;
      tx_word   <= '0;
      dir_q     <= 1'b0;
      match_q   <= 1'b0;
      oob_q     <= 1'b0;
      acc_ovf   <= 1'b0;
      acc_unf   <= 1'b0;
      lock_q    <= '0;
      prev      <= '0;
    end else begin
      reg_rd  <= 1'b0;
      reg_wr  <= 1'b0;
      rst_req <= 1'b0;
      if (f_start) begin
        acc_ovf <= fifo_ovf;
        acc_unf <= fifo_unf;
      end else begin
        acc_ovf <= acc_ovf | fifo_ovf;
        acc_unf <= acc_unf | fifo_unf;
      end
      if (f_start) begin
        dir_q   <= 1'b0;
        match_q <= 1'b0;
        oob_q   <= 1'b0;
        tx_word <= '0;
      end else if (cmd_ready) begin
        reg_addr <= c_addr;
        dir_q    <= c_dir;
        match_q  <= c_match;
        oob_q    <= c_match && c_oob;
        tx_word  <= '0;
        if (c_match && c_dir && !c_oob) begin
          if (c_addr == LOCK_ADDR)     tx_word <= lock_q;
          else if (c_addr != RST_ADDR) reg_rd  <= 1'b1;
        end
      end else if (reg_rd) begin
        tx_word <= reg_rdata;
      end
      if (f_stop) begin
        prev.len_err <= (bit_cnt != C_FRAME);
        prev.mis     <= (bit_cnt >= C_CMD) && !match_q;
        prev.oob     <= oob_q;
        prev.dpar    <= dir_q ? ^tx_word : ^rx_word;
        reg_wdata    <= rx_word;
        if (clean) begin
          if (reg_addr == LOCK_ADDR)     lock_q  <= rx_word;
          else if (reg_addr == RST_ADDR) rst_req <= (rx_word == RST_KEY);
          else                           reg_wr  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsf_spi_slave.sv
module rsf_spi_slave #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int STAT_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] REG_TOP   = 11'h3FF,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 11'h325,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 11'h322,
  parameter logic [DATA_W-1:0] RST_KEY   = 32'h8100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sel_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_en,
  input  logic              fifo_ovf,
  input  logic              fifo_unf,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              rst_req
);
  localparam int CMD_BITS = 2 * ADDR_W + 2;
  localparam int FRAME_BITS = CMD_BITS + STAT_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic [2:0] pins_s;
  logic f_start, f_stop, cmd_ready, lock_on;
  logic [CMD_BITS-1:0] cmd;
  logic [DATA_W-1:0] rx_word, tx_word;
  logic [CNT_W-1:0] bit_cnt;
  logic [STAT_W-1:0] status;

  rsf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_sel_n, spi_sck, spi_mosi}), .q(pins_s)
  );

  rsf_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sel_n_s(pins_s[2]), .sck_s(pins_s[1]), .mosi_s(pins_s[0]),
    .status_in(status), .tx_word(tx_word),
    .f_start(f_start), .f_stop(f_stop), .cmd_ready(cmd_ready),
    .cmd(cmd), .rx_word(rx_word), .bit_cnt(bit_cnt),
    .miso(spi_miso), .miso_en(spi_miso_en)
  );

  rsf_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W), .REG_TOP(REG_TOP),
    .LOCK_ADDR(LOCK_ADDR), .RST_ADDR(RST_ADDR), .RST_KEY(RST_KEY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .f_start(f_start), .f_stop(f_stop),
    .cmd_ready(cmd_ready), .cmd(cmd), .rx_word(rx_word), .bit_cnt(bit_cnt),
    .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .rst_req(rst_req), .locked(lock_on),
    .tx_word(tx_word), .status(status)
  );
endmodule

// File: rtl/rsf_chk.sv
module rsf_chk #(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] REG_TOP   = 11'h3FF,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 11'h325,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 11'h322
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_sel_n,
  input logic              spi_miso_en,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rst_req,
  input logic              locked
);
  // R6: bus reads never leave the implemented range
  assert_rd_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> reg_addr <= REG_TOP);

  // R5 R8 R9: forwarded writes target ordinary words only
  assert_wr_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr <= REG_TOP && reg_addr != LOCK_ADDR && reg_addr != RST_ADDR));

  // R8: no forwarded write while the lock is armed
  assert_wr_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !locked);

  // R9: reset request lasts one cycle
  assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5: reads and writes never share a cycle
  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  // R11: output released while select has been high for three cycles
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sel_n && $past(spi_sel_n) && $past(spi_sel_n, 2)) |-> !spi_miso_en);
endmodule

bind rsf_spi_slave rsf_chk #(
  .ADDR_W(ADDR_W), .REG_TOP(REG_TOP), .LOCK_ADDR(LOCK_ADDR), .RST_ADDR(RST_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_miso_en(spi_miso_en),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .rst_req(rst_req),
  .locked(lock_on)
);

// File: tb/sim_rsf_spi_slave.sv
module sim_rsf_spi_slave;
  localparam int CLK_PERIOD = 10;
  localparam int SPI_HALF = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sel_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_en;
  logic fifo_ovf = 1'b0, fifo_unf = 1'b0;
  logic [10:0] reg_addr;
  logic reg_rd, reg_wr, rst_req;
  logic [31:0] reg_wdata, reg_rdata;

  logic [31:0] mem [1024];
  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0, wr_cnt = 0, rst_cnt = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  st;
    logic [31:0] dat;
    bit          chk_dat;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] got_st;
  logic [31:0] got_dat;
  bit got_tail_zero;
  event frame_done;

  bit e_ovf = 0, e_unf = 0, e_dpar = 0, e_mis = 0, e_len = 0, e_oob = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsf_spi_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sel_n(spi_sel_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_en(spi_miso_en),
    .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rst_req(rst_req)
  );

  assign reg_rdata = mem[reg_addr[9:0]];

  always @(posedge clk) begin
    if (reg_wr) mem[reg_addr[9:0]] <= reg_wdata;
    if (reg_wr) wr_cnt <= wr_cnt + 1;
    if (reg_rd) rd_cnt <= rd_cnt + 1;
    if (rst_req) rst_cnt <= rst_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] model_status();
    logic [7:0] b;
    b = {1'b0, e_ovf, e_unf, e_dpar, e_mis, 1'b0, e_len, e_oob};
    b[7] = ^b[6:0];
    return b;
  endfunction

  // Monitor: pops the expected frame result and compares it with what was shifted out
  initial begin
    forever begin
      @(frame_done);
      if (exp_q.size() == 0) begin
        check(0, "scoreboard empty", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(got_st === e.st, {e.tag, " status"}, 64'(got_st), 64'(e.st));
        if (e.chk_dat) begin
          check(got_dat === e.dat, {e.tag, " read data"}, 64'(got_dat), 64'(e.dat));
          check(got_tail_zero, {e.tag, " zero fill"}, 64'(got_tail_zero), 64'd1);
        end
      end
    end
  end

  // Driver: one frame, bit by bit; pushes the predicted result before sending
  task automatic xfer(input logic [10:0] a, input logic rd, input bit bad, input int nbits,
                      input logic [31:0] wd, input logic [31:0] exp_rd, input bit exp_oob,
                      input string tag);
    logic [63:0] tx;
    logic [31:0] rxw;
    exp_t e;
    tx = {a, rd, ~a ^ (bad ? 11'h004 : 11'h000), ~rd, 8'h00, rd ? 32'h0 : wd};
    e.st = model_status();
    e.dat = exp_rd;
    e.chk_dat = rd && (nbits >= 64);
    e.tag = tag;
    exp_q.push_back(e);
    e_ovf = 0;
    e_unf = 0;
    got_st = '0;
    got_dat = '0;
    got_tail_zero = 1;
    rxw = '0;
    @(negedge clk);
    spi_sel_n = 1'b0;
    #(SPI_HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 64) ? tx[63-i] : 1'b0;
      if (i >= 32 && i < 64) rxw = {rxw[30:0], tx[63-i]};
      #(SPI_HALF);
      if (i >= 24 && i < 32) got_st = {got_st[6:0], spi_miso};
      else if (i >= 32 && i < 64) got_dat = {got_dat[30:0], spi_miso};
      else if (i >= 64 && spi_miso !== 1'b0) got_tail_zero = 0;
      spi_sck = 1'b1;
      #(SPI_HALF);
      spi_sck = 1'b0;
    end
    #(SPI_HALF);
    spi_sel_n = 1'b1;
    repeat (30) @(negedge clk);
    ->frame_done;
    e_len = (nbits != 64);
    e_mis = (nbits >= 24) && bad;
    e_oob = (nbits >= 24) && !bad && exp_oob;
    e_dpar = rd ? ((nbits >= 24) ? ^exp_rd : 1'b0) : ^rxw;
    #1;
  endtask

  task automatic pulse_ovf();
    @(negedge clk); fifo_ovf = 1'b1;
    @(negedge clk); fifo_ovf = 1'b0;
    e_ovf = 1;
  endtask

  task automatic pulse_unf();
    @(negedge clk); fifo_unf = 1'b1;
    @(negedge clk); fifo_unf = 1'b0;
    e_unf = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int rd0, wr0;
    for (int i = 0; i < 1024; i++) mem[i] = (32'(i) * 32'h0101_0101) ^ 32'hA500_3C00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    check(rst_req === 1'b0 && reg_wr === 1'b0, "R12 reset outputs", {rst_req, reg_wr}, 0);
    check(spi_miso_en === 1'b0, "R11 idle enable", spi_miso_en, 0);

    // R1 R12: first read, status must be zero
    xfer(11'h005, 1, 0, 64, 0, mem[5], 0, "R12 R1");
    check(rd_cnt == 1, "R1 single bus read", rd_cnt, 1);

    // R5 R7: clean write, then read back with parity of the written word
    xfer(11'h010, 0, 0, 64, 32'h1234_5678, 0, 0, "R7 R5");
    check(mem[16] === 32'h1234_5678 && wr_cnt == 1, "R5 write commit", mem[16], 32'h1234_5678);
    xfer(11'h010, 1, 0, 64, 0, 32'h1234_5678, 0, "R7 R1");

    // R3: corrupted complement field on a write and on a read
    wr0 = wr_cnt;
    xfer(11'h011, 0, 1, 64, 32'hFFFF_0000, 0, 0, "R7 R2");
    check(wr_cnt == wr0 && mem[17] === ((32'd17 * 32'h0101_0101) ^ 32'hA500_3C00),
          "R3 no write on mismatch", wr_cnt, wr0);
    rd0 = rd_cnt;
    xfer(11'h005, 1, 1, 64, 0, 32'h0, 0, "R3 write mismatch flagged");
    check(rd_cnt == rd0, "R3 no read on mismatch", rd_cnt, rd0);

    // R4: short, long write frames and a long read
    wr0 = wr_cnt;
    xfer(11'h012, 0, 0, 63, 32'hCAFE_F00D, 0, 0, "R3 read mismatch flagged");
    xfer(11'h012, 0, 0, 65, 32'hCAFE_F00D, 0, 0, "R4 short frame flagged");
    check(wr_cnt == wr0, "R4 no commit on bad length", wr_cnt, wr0);
    xfer(11'h005, 1, 0, 70, 0, mem[5], 0, "R4 long frame flagged");

    // R6: out-of-bounds read and write
    xfer(11'h500, 1, 0, 64, 0, 32'h0, 1, "R4 extra clocks flagged");
    wr0 = wr_cnt;
    xfer(11'h600, 0, 0, 64, 32'h1111_2222, 0, 1, "R6 oob read flagged");
    check(wr_cnt == wr0, "R6 no write out of range", wr_cnt, wr0);

    // R8: lock arm, blocked write, read-back, unlock
    xfer(11'h325, 0, 0, 64, 32'h8000_0000, 0, 0, "R6 oob write flagged");
    wr0 = wr_cnt;
    xfer(11'h020, 0, 0, 64, 32'h0BAD_0BAD, 0, 1, "R8 lock write");
    check(wr_cnt == wr0, "R8 write blocked", wr_cnt, wr0);
    xfer(11'h020, 1, 0, 64, 0, (32'd32 * 32'h0101_0101) ^ 32'hA500_3C00, 0, "R8 blocked flagged");
    xfer(11'h325, 1, 0, 64, 0, 32'h8000_0000, 0, "R8 read lock word");
    xfer(11'h325, 0, 0, 64, 32'h0, 0, 0, "R8 R7");
    xfer(11'h020, 0, 0, 64, 32'h0600_D000, 0, 0, "R8 unlock");
    check(mem[32] === 32'h0600_D000, "R8 write after unlock", mem[32], 32'h0600_D000);

    // R9: reset trigger word
    xfer(11'h322, 0, 0, 64, 32'h1234_5678, 0, 0, "R8 R2");
    check(rst_cnt == 0, "R9 wrong key ignored", rst_cnt, 0);
    xfer(11'h322, 0, 0, 64, 32'h8100_0000, 0, 0, "R9 R2");
    check(rst_cnt == 1, "R9 single reset pulse", rst_cnt, 1);

    // R10: FIFO event flags appear once
    pulse_ovf();
    xfer(11'h005, 1, 0, 64, 0, mem[5], 0, "R10 overrun flag");
    pulse_unf();
    xfer(11'h006, 1, 0, 64, 0, mem[6], 0, "R10 overrun cleared underrun set");

    // R11: activity while deselected has no effect
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    for (int i = 0; i < 40; i++) begin
      spi_mosi = i[0];
      #(SPI_HALF) spi_sck = 1'b1;
      #(SPI_HALF) spi_sck = 1'b0;
    end
    @(negedge clk);
    check(spi_miso_en === 1'b0, "R11 enable low while deselected", spi_miso_en, 0);
    check(rd_cnt == rd0 && wr_cnt == wr0, "R11 no access while deselected", rd_cnt + wr_cnt, rd0 + wr0);
    xfer(11'h007, 1, 0, 64, 0, mem[7], 0, "R11 R10 status unchanged");
    xfer(11'h008, 1, 0, 64, 0, mem[8], 0, "R2 R7 final");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule